// File: doc/BRIEF.md
# DDS Frequency Tuning-Word Generator

This block turns a frequency request, given as nine packed BCD digits counting in steps of 0.1 Hz, into the 32-bit phase-increment word for a direct digital synthesizer running from a 130 MHz reference. It is meant to sit between a command decoder, which has gathered decimal digits from a user, and the logic that loads the tuning word into the synthesizer.

A request enters on a valid/ready input stream. While a request is in flight, `in_ready` stays low, so an upstream source that holds `in_valid` simply waits. Back-pressure is honoured on the output side: a finished result stays on the output, unchanged, until the consumer raises `out_ready`.

Inside, the digits are folded into a binary count one digit per clock, most significant first. The count is then checked against the 35 MHz ceiling and multiplied by a fixed-point reciprocal of the reference. The product is rounded to the nearest integer. Requests above the ceiling, or requests holding a non-decimal digit, raise a range flag and return the ceiling word.

Top module: `dds_tuning_word_gen`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle until its result has been handed over, `in_ready` is 0. Digits or `in_valid` pulses presented during that time have no effect on the result.
- R3: `in_digits[4k+3:4k]` is the decimal digit of weight 10^k (k = 0 for the least significant, k = 8 for the most significant). The value f counts in units of 0.1 Hz.
- R4: For f <= 350,000,000 with all digits 0..9, `out_word` = floor((f * 2^32 + 650,000,000) / 1,300,000,000), and `out_range_err` = 0.
- R5: For f > 350,000,000, `out_range_err` = 1 and `out_word` = 1,156,337,349, which is the word for 35 MHz.
- R6: If any digit is greater than 9, `out_range_err` = 1 and `out_word` = 1,156,337,349, whatever the other digits are.
- R7: `out_valid` rises exactly DIGITS+1 rising edges after the accepting edge. With the default of nine digits, that is 10 edges.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word` and `out_range_err` hold steady. The handover happens on an edge where both are 1, and `out_valid` is 0 in the following cycle.
- R9: Each accepted request produces exactly one output handover. No result appears without a new accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_digits | input | 36 | Nine packed BCD digits, 0.1 Hz units, least significant digit in bits 3:0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Phase-increment word |
| out_range_err | output | 1 | Request above 35 MHz or holding a non-decimal digit |

## Verification
The bench builds the block with its defaults: nine digits, a 32-bit word, 56 fractional bits in the scale constant, and the 130 MHz and 35 MHz limits. With 56 fractional bits, the scaling error stays far below the smallest distance any product can have from a half-LSB rounding boundary. Every request up to the ceiling can therefore be compared word for word against an exact integer division. The nine-digit width puts both the exact 35 MHz boundary and the all-nines input within reach, and a single corrupted digit can be placed at any position.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int NIBBLE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SCALE = 2'd2,
    ST_HOLD  = 2'd3
  } dtw_state_e;
endpackage

// File: rtl/bcd_serial_accum.sv
module bcd_serial_accum #(
  parameter int DIGITS = 9,
  parameter int BIN_W  = 30
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic                            step,
  input  logic [dtw_pkg::NIBBLE_W*DIGITS-1:0] digits_in,
  output logic [BIN_W-1:0]                bin_out,
  output logic                            bad_out,
  output logic                            last
);
  localparam int SH_W  = dtw_pkg::NIBBLE_W * DIGITS;
  localparam int CNT_W = $clog2(DIGITS + 1);

  logic [SH_W-1:0]  shreg;
  logic [BIN_W-1:0] acc;
  logic [BIN_W-1:0] acc_next;
  logic             bad;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cur;

  always_comb begin
    cur      = shreg[SH_W-1 -: 4];
    acc_next = BIN_W'(acc * 4'd10) + BIN_W'(cur);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      acc   <= '0;
      bad   <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      shreg <= digits_in;
      acc   <= '0;
      bad   <= 1'b0;
      cnt   <= '0;
    end else if (step) begin
      acc   <= acc_next;
      bad   <= bad | (cur > 4'd9);
      shreg <= shreg << 4;
      cnt   <= cnt + CNT_W'(1);
    end
  end

  assign bin_out = acc;
  assign bad_out = bad;
  assign last    = (cnt == CNT_W'(DIGITS - 1));

  // R7: no more than DIGITS digits are ever folded in
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DIGITS));
endmodule

// File: rtl/tw_scaler.sv
module tw_scaler #(
  parameter int              BIN_W   = 30,
  parameter int              WORD_W  = 32,
  parameter int              FRAC_W  = 56,
  parameter longint unsigned REF_X10 = 64'd1_300_000_000,
  parameter longint unsigned MAX_X10 = 64'd350_000_000
) (
  input  logic [BIN_W-1:0]  bin,
  input  logic              bad,
  output logic [WORD_W-1:0] word,
  output logic              over
);
  localparam int K_W    = WORD_W + FRAC_W - $clog2(REF_X10) + 1;
  localparam int PROD_W = BIN_W + K_W;
  localparam logic [127:0] K_FULL =
    ((128'd1 << (WORD_W + FRAC_W)) + 128'(REF_X10 / 2)) / 128'(REF_X10);
  localparam logic [K_W-1:0]   K   = K_W'(K_FULL);
  localparam logic [BIN_W-1:0] CAP = BIN_W'(MAX_X10);

  logic [BIN_W-1:0]  eff;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rnd;

  always_comb begin
    over = bad | (bin > CAP);
    eff  = over ? CAP : bin;
    prod = {{K_W{1'b0}}, eff} * {{BIN_W{1'b0}}, K};
    rnd  = prod + (PROD_W'(1) << (FRAC_W - 1));
    word = WORD_W'(rnd >> FRAC_W);
  end
endmodule

// File: rtl/dds_tuning_word_gen.sv
module dds_tuning_word_gen #(
  parameter int              DIGITS  = 9,
  parameter int              WORD_W  = 32,
  parameter int              FRAC_W  = 56,
  parameter longint unsigned REF_X10 = 64'd1_300_000_000,
  parameter longint unsigned MAX_X10 = 64'd350_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [4*DIGITS-1:0]      in_digits,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [WORD_W-1:0]        out_word,
  output logic                     out_range_err
);
  import dtw_pkg::*;

  localparam int BIN_W = $clog2(10 ** DIGITS);
  localparam logic [127:0] CAP_FULL =
    ((128'(MAX_X10) << WORD_W) + 128'(REF_X10 / 2)) / 128'(REF_X10);
  localparam logic [WORD_W-1:0] WORD_CAP = WORD_W'(CAP_FULL);

  dtw_state_e       state;
  logic             load;
  logic             step;
  logic             last;
  logic [BIN_W-1:0] bin;
  logic             bad;
  logic [WORD_W-1:0] sc_word;
  logic             sc_over;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign load      = in_valid && in_ready;
  assign step      = (state == ST_CONV);

  bcd_serial_accum #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .digits_in(in_digits),
    .bin_out  (bin),
    .bad_out  (bad),
    .last     (last)
  );

  tw_scaler #(
    .BIN_W(BIN_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W),
    .REF_X10(REF_X10), .MAX_X10(MAX_X10)
  ) u_scale (
    .bin (bin),
    .bad (bad),
    .word(sc_word),
    .over(sc_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      out_word      <= '0;
      out_range_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (load) state <= ST_CONV;
        ST_CONV:  if (last) state <= ST_SCALE;
        ST_SCALE: begin
          out_word      <= sc_word;
          out_range_err <= sc_over;
          state         <= ST_HOLD;
        end
        ST_HOLD:  if (out_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: a taken request makes the block busy on the next cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R8: result held steady under back-pressure
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_range_err)));

  // R8: a handover retires the result
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);

  // R5: a flagged result carries the ceiling word
  assert_clamp_value_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_range_err) |-> (out_word == WORD_CAP));

  // R4: no word ever exceeds the ceiling word
  assert_word_limit_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word <= WORD_CAP));
endmodule

// File: tb/dds_tuning_word_gen_tb.sv
`timescale 1ns/1ps
module dds_tuning_word_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_digits = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_range_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam longint unsigned CEIL_WORD = 64'd1_156_337_349;

  always #4 clk = ~clk;

  dds_tuning_word_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_digits(in_digits), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_range_err(out_range_err)
  );

  function automatic logic [35:0] to_bcd(longint unsigned v);
    logic [35:0] d = '0;
    for (int k = 0; k < 9; k++) begin
      d[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return d;
  endfunction

  function automatic longint unsigned ref_word(longint unsigned f);
    return ((f << 32) + 64'd650_000_000) / 64'd1_300_000_000;
  endfunction

  task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(logic [35:0] d);
    @(negedge clk);
    in_digits = d;
    in_valid  = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_out(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      #1;
    end while (!out_valid && lat < 60);
  endtask

  task automatic finish_xfer();
    @(posedge clk);
    #1 chk(out_valid == 1'b0, "R8 release", out_valid, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
  endtask

  task automatic t_in_range();
    longint unsigned vals[8] = '{0, 1, 9, 10_000_000, 123_456_789,
                                 270_000_001, 349_999_999, 350_000_000};
    foreach (vals[i]) begin
      int lat;
      start(to_bcd(vals[i]));
      wait_out(lat);
      chk(lat == 10, "R7 latency", lat, 10);
      chk(out_word == 32'(ref_word(vals[i])), "R3 R4 word", out_word, ref_word(vals[i]));
      chk(out_range_err == 1'b0, "R4 flag", out_range_err, 0);
      finish_xfer();
    end
  endtask

  task automatic t_over();
    longint unsigned vals[3] = '{350_000_001, 500_000_000, 999_999_999};
    foreach (vals[i]) begin
      int lat;
      start(to_bcd(vals[i]));
      wait_out(lat);
      chk(out_range_err == 1'b1, "R5 flag", out_range_err, 1);
      chk(out_word == 32'(CEIL_WORD), "R5 clamp", out_word, CEIL_WORD);
      finish_xfer();
    end
  endtask

  task automatic t_bad_digit();
    logic [35:0] d;
    int lat;
    d = to_bcd(12_345_678);
    d[19:16] = 4'hC;
    start(d);
    wait_out(lat);
    chk(out_range_err == 1'b1, "R6 flag mid digit", out_range_err, 1);
    chk(out_word == 32'(CEIL_WORD), "R6 clamp mid digit", out_word, CEIL_WORD);
    finish_xfer();
    d = to_bcd(1);
    d[35:32] = 4'hF;
    start(d);
    wait_out(lat);
    chk(out_range_err == 1'b1, "R6 flag top digit", out_range_err, 1);
    chk(out_word == 32'(CEIL_WORD), "R6 clamp top digit", out_word, CEIL_WORD);
    finish_xfer();
  endtask

  task automatic t_backpressure();
    int lat;
    longint unsigned exp_w = ref_word(200_000_000);
    out_ready = 1'b0;
    start(to_bcd(200_000_000));
    wait_out(lat);
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1;
      chk(out_valid == 1'b1, "R8 held valid", out_valid, 1);
      chk(out_word == 32'(exp_w), "R8 held word", out_word, exp_w);
      chk(in_ready == 1'b0, "R2 busy while held", in_ready, 0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    finish_xfer();
  endtask

  task automatic t_busy_ignore();
    int lat;
    longint unsigned exp_w = ref_word(55_555_555);
    start(to_bcd(55_555_555));
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_digits = to_bcd(300_000_000 + c);
      #1 chk(in_ready == 1'b0, "R2 busy", in_ready, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(lat);
    chk(out_word == 32'(exp_w), "R2 ignored digits", out_word, exp_w);
    finish_xfer();
    for (int c = 0; c < 15; c++) begin
      @(posedge clk);
      #1 chk(out_valid == 1'b0, "R9 single result", out_valid, 0);
    end
    chk(in_ready == 1'b1, "R9 idle again", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_in_range();
    t_over();
    t_bad_digit();
    t_backpressure();
    t_busy_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule